// File: doc/BRIEF.md
# Descriptor-Driven DMA Loop Engine

This block runs a single DMA channel from a transfer control descriptor held in its own registers. The descriptor is written in one cycle through a set of configuration inputs. Each service request runs one major-loop iteration. A service request is a software start pulse, a peripheral request or an incoming link from another channel. One iteration is a complete minor loop that moves `nbytes` bytes. The bytes travel as source-sized reads and destination-sized writes over a simple request/acknowledge memory port.

After every beat, the source and destination addresses advance by their own signed 16-bit offsets. An optional per-side modulo keeps the address inside a power-of-two circular window. The engine keeps a current iteration count that falls by one at each minor-loop end. When that count runs out, the major loop is complete, and the engine does the following:
- adds a signed 32-bit last-address adjustment to each address;
- reloads the count from the beginning count;
- sets the done flag;
- raises the configured interrupt and link pulses.

A surrounding channel arbiter would use the link outputs to start other channels.

Top module: `dma_loop_engine`

## Requirements
- R1: After reset the block is idle with `memReq`, `activeFlag`, `doneFlag` and all pulse outputs low, `curCount` at 0 and `cfgErr` high, because the byte count is zero.
- R2: Size codes 0, 1 and 2 mean 1, 2 and 4 bytes. Data moves in units of the larger of the two sizes. Each unit is read as consecutive source beats and then written as consecutive destination beats. Bytes are packed little-endian: a byte from a lower read address lands in a lower lane, and lane 0 is `memWdata[7:0]`. Bytes from a lower lane go to the lower write address. `memSize` carries the size code of the current beat.
- R3: After each read beat the source address advances by the sign-extended 16-bit source offset. After each write beat the destination address advances by the sign-extended destination offset.
- R4: A nonzero modulo value m on a side keeps address bits 31..m fixed when that side's offset is added. Only bits m-1..0 take the sum. A modulo value of 0 means a plain add.
- R5: One accepted request runs exactly one minor loop of `nbytes` bytes and then stops. `activeFlag` is high from the cycle after acceptance until the loop ends. `curCount` drops by one at the end of each minor loop that is not the last of the major loop. Requests seen while active are ignored.
- R6: When the minor loop that brings the count to zero ends, the signed last-source adjustment is added to the source address and the signed last-destination adjustment to the destination address. These are added after the final beat's offset. `curCount` reloads from the beginning count (`cfgIter[14:0]`) and `doneFlag` sets. `doneFlag` clears when the next request is accepted or a descriptor is loaded.
- R7: With the half-point enable set, `irqHalf` pulses for one cycle at a minor-loop end whose new count equals the beginning count shifted right by one, when that value is nonzero.
- R8: With the major enable set, `irqMajor` pulses for one cycle at the end of the major loop, together with `doneFlag` going high.
- R9: When `cfgIter[15]` is set, `linkReq` pulses for one cycle with `linkCh` equal to the minor link channel at the end of every minor loop except the last of the major loop.
- R10: When major linking is enabled, `linkReq` pulses with `linkCh` equal to the major link channel at the end of the major loop.
- R11: If the stop-peripheral bit is set, `periphReq` is ignored after the major loop completes, until the next descriptor load. `swStart` and `linkIn` still start iterations.
- R12: `cfgErr` is high, and every request is ignored, when a size code is above 2, `nbytes` is zero or not a multiple of the larger size, or the beginning count is zero.
- R13: A descriptor loaded with the start bit set starts one iteration by itself, with no external request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgLoad | input | 1 | Load descriptor (accepted while idle) |
| cfgSrcAddr | input | 32 | Source start address |
| cfgDstAddr | input | 32 | Destination start address |
| cfgSrcOff | input | 16 | Signed source offset per read beat |
| cfgDstOff | input | 16 | Signed destination offset per write beat |
| cfgSrcSize | input | 3 | Source size code |
| cfgDstSize | input | 3 | Destination size code |
| cfgSrcMod | input | 5 | Source modulo bit count (0 = off) |
| cfgDstMod | input | 5 | Destination modulo bit count (0 = off) |
| cfgNBytes | input | 32 | Bytes per minor loop |
| cfgSrcLastAdj | input | 32 | Signed source adjustment at major end |
| cfgDstLastAdj | input | 32 | Signed destination adjustment at major end |
| cfgIter | input | 16 | Bit 15 minor link enable, bits 14..0 beginning count |
| cfgMinorLinkCh | input | 6 | Channel linked at minor-loop ends |
| cfgMajorLinkEn | input | 1 | Enable link at major end |
| cfgMajorLinkCh | input | 6 | Channel linked at major end |
| cfgHalfIrqEn | input | 1 | Enable half-point interrupt |
| cfgMajorIrqEn | input | 1 | Enable major-completion interrupt |
| cfgStopPeriphAtDone | input | 1 | Ignore peripheral requests after major end |
| cfgStart | input | 1 | Start one iteration on load |
| swStart | input | 1 | Software request pulse |
| periphReq | input | 1 | Peripheral request |
| linkIn | input | 1 | Link request from another channel |
| memReq | output | 1 | Memory beat request, held until acknowledged |
| memWe | output | 1 | 1 = write beat, 0 = read beat |
| memAddr | output | 32 | Beat address |
| memSize | output | 2 | Beat size code |
| memWdata | output | 32 | Write data, low-lane aligned |
| memAck | input | 1 | Beat accepted (read data valid) |
| memRdata | input | 32 | Read data, low-lane aligned |
| curCount | output | 15 | Current iteration count |
| activeFlag | output | 1 | Channel transferring |
| doneFlag | output | 1 | Major loop completed |
| cfgErr | output | 1 | Descriptor rejected |
| irqHalf | output | 1 | Half-point interrupt pulse |
| irqMajor | output | 1 | Major-completion interrupt pulse |
| linkReq | output | 1 | Link request pulse |
| linkCh | output | 6 | Channel for `linkReq` |

## Verification
The hardest situation to reach from the ports is a source window that wraps in the middle of a minor loop. In the same case the packing must work with a wider destination and a negative offset. The bench sets this up with a 3-bit source modulo and a start address four bytes below the top of an 8-byte window. Byte reads then wrap back to the window base while 4-byte writes walk downward. A second major loop follows, so the last-destination adjustment shows up in the next write addresses. Link ordering is reached by mixing peripheral, link and software requests against a two-iteration descriptor that has minor linking enabled.

// File: rtl/dma_loop_pkg.sv
package dma_loop_pkg;
  typedef struct packed {
    logic loadCfg;   // capture descriptor
    logic rdBeat;    // read beat acknowledged
    logic wrBeat;    // write beat acknowledged
    logic minorEnd;  // minor loop finished
    logic majorEnd;  // major loop finished
    logic wrSel;     // memory port in write phase
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_READ,
    ST_WRITE,
    ST_FINISH
  } loopState_t;
endpackage

// File: rtl/dma_loop_datapath.sv
module dma_loop_datapath
  import dma_loop_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int NB_W   = 32,
  parameter int DATA_W = 32,
  parameter int MOD_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [ADDR_W-1:0] cfgSrcAddr,
  input  logic [ADDR_W-1:0] cfgDstAddr,
  input  logic [OFF_W-1:0]  cfgSrcOff,
  input  logic [OFF_W-1:0]  cfgDstOff,
  input  logic [2:0]        cfgSrcSize,
  input  logic [2:0]        cfgDstSize,
  input  logic [MOD_W-1:0]  cfgSrcMod,
  input  logic [MOD_W-1:0]  cfgDstMod,
  input  logic [NB_W-1:0]   cfgNBytes,
  input  logic [ADDR_W-1:0] cfgSrcLastAdj,
  input  logic [ADDR_W-1:0] cfgDstLastAdj,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        memSize,
  output logic [DATA_W-1:0] memWdata,
  output logic              cfgBad,
  output logic              rdUnitLast,
  output logic              wrUnitLast,
  output logic              minorLast
);
  localparam int LANES     = DATA_W / 8;
  localparam int OFS_W     = $clog2(LANES) + 1;
  localparam int MAX_CODE  = $clog2(LANES);

  logic [ADDR_W-1:0] srcAddr, dstAddr, srcLast, dstLast;
  logic [OFF_W-1:0]  srcOff, dstOff;
  logic [MOD_W-1:0]  srcMod, dstMod;
  logic [2:0]        srcSize, dstSize;
  logic [NB_W-1:0]   nBytes, bytesLeft;
  logic [OFS_W-1:0]  rdOff, wrOff, sBytes, dBytes, unitBytes;
  logic [DATA_W-1:0] dataBuf, bufNext, wMask, wShift;

  function automatic logic [ADDR_W-1:0] stepAddr(input logic [ADDR_W-1:0] a,
                                                 input logic [OFF_W-1:0] off,
                                                 input logic [MOD_W-1:0] m);
    logic [ADDR_W-1:0] sum, keep;
    sum  = a + {{(ADDR_W-OFF_W){off[OFF_W-1]}}, off};
    keep = (m == '0) ? '0 : ({ADDR_W{1'b1}} << m);
    return (a & keep) | (sum & ~keep);
  endfunction

  assign sBytes    = OFS_W'(1) << srcSize[1:0];
  assign dBytes    = OFS_W'(1) << dstSize[1:0];
  assign unitBytes = (sBytes > dBytes) ? sBytes : dBytes;

  assign cfgBad = (srcSize > 3'(MAX_CODE)) || (dstSize > 3'(MAX_CODE)) ||
                  (nBytes == '0) ||
                  ((nBytes & (NB_W'(unitBytes) - NB_W'(1))) != '0);

  assign rdUnitLast = (rdOff + sBytes) == unitBytes;
  assign wrUnitLast = (wrOff + dBytes) == unitBytes;
  assign minorLast  = bytesLeft == NB_W'(dBytes);

  always_comb begin
    bufNext = dataBuf;
    for (int b = 0; b < LANES; b++) begin
      logic [OFS_W-1:0]  laneIdx;
      logic [OFS_W-1:0]  rel;
      logic [DATA_W-1:0] shifted;
      laneIdx = OFS_W'(b);
      rel     = laneIdx - rdOff;
      shifted = memRdata >> {rel, 3'b000};
      if (laneIdx >= rdOff && laneIdx < rdOff + sBytes)
        bufNext[b*8 +: 8] = shifted[7:0];
    end
  end

  assign wShift   = dataBuf >> {wrOff, 3'b000};
  assign wMask    = ~({DATA_W{1'b1}} << {dBytes, 3'b000});
  assign memWdata = wShift & wMask;
  assign memAddr  = stb.wrSel ? dstAddr : srcAddr;
  assign memSize  = stb.wrSel ? dstSize[1:0] : srcSize[1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcAddr <= '0; dstAddr <= '0; srcLast <= '0; dstLast <= '0;
      srcOff <= '0; dstOff <= '0; srcMod <= '0; dstMod <= '0;
      srcSize <= '0; dstSize <= '0; nBytes <= '0; bytesLeft <= '0;
      rdOff <= '0; wrOff <= '0; dataBuf <= '0;
    end else if (stb.loadCfg) begin
      srcAddr   <= cfgSrcAddr;    dstAddr <= cfgDstAddr;
      srcLast   <= cfgSrcLastAdj; dstLast <= cfgDstLastAdj;
      srcOff    <= cfgSrcOff;     dstOff  <= cfgDstOff;
      srcMod    <= cfgSrcMod;     dstMod  <= cfgDstMod;
      srcSize   <= cfgSrcSize;    dstSize <= cfgDstSize;
      nBytes    <= cfgNBytes;     bytesLeft <= cfgNBytes;
      rdOff     <= '0;            wrOff   <= '0;
      dataBuf   <= '0;
    end else begin
      if (stb.rdBeat) begin
        srcAddr <= stepAddr(srcAddr, srcOff, srcMod);
        dataBuf <= bufNext;
        rdOff   <= rdUnitLast ? '0 : rdOff + sBytes;
      end
      if (stb.wrBeat) begin
        dstAddr   <= stepAddr(dstAddr, dstOff, dstMod);
        bytesLeft <= bytesLeft - NB_W'(dBytes);
        wrOff     <= wrUnitLast ? '0 : wrOff + dBytes;
      end
      if (stb.minorEnd) bytesLeft <= nBytes;
      if (stb.majorEnd) begin
        srcAddr <= srcAddr + srcLast;
        dstAddr <= dstAddr + dstLast;
      end
    end
  end
endmodule

// File: rtl/dma_loop_ctrl.sv
module dma_loop_ctrl
  import dma_loop_pkg::*;
#(
  parameter int CNT_W = 15,
  parameter int CH_W  = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgLoad,
  input  logic [CNT_W:0]   cfgIter,
  input  logic [CH_W-1:0]  cfgMinorLinkCh,
  input  logic             cfgMajorLinkEn,
  input  logic [CH_W-1:0]  cfgMajorLinkCh,
  input  logic             cfgHalfIrqEn,
  input  logic             cfgMajorIrqEn,
  input  logic             cfgStopPeriphAtDone,
  input  logic             cfgStart,
  input  logic             swStart,
  input  logic             periphReq,
  input  logic             linkIn,
  input  logic             memAck,
  input  logic             cfgBad,
  input  logic             rdUnitLast,
  input  logic             wrUnitLast,
  input  logic             minorLast,
  output dpStrobe_t        stb,
  output logic             memReq,
  output logic             memWe,
  output logic [CNT_W-1:0] curCount,
  output logic             activeFlag,
  output logic             doneFlag,
  output logic             cfgErr,
  output logic             irqHalf,
  output logic             irqMajor,
  output logic             linkReq,
  output logic [CH_W-1:0]  linkCh
);
  loopState_t       state;
  logic [CNT_W-1:0] beginCount, countDec;
  logic [CH_W-1:0]  minorCh, majorCh;
  logic minorLinkEn, majorLinkEn, halfEn, majorEn, stopPeriph;
  logic periphOn, startPend, go, lastIter;

  assign cfgErr   = cfgBad || (beginCount == '0);
  assign go       = (state == ST_IDLE) && !cfgErr &&
                    (swStart || startPend || linkIn || (periphReq && periphOn));
  assign countDec = curCount - CNT_W'(1);
  assign lastIter = (curCount == CNT_W'(1));

  assign stb.loadCfg  = cfgLoad && (state == ST_IDLE);
  assign stb.rdBeat   = (state == ST_READ) && memAck;
  assign stb.wrBeat   = (state == ST_WRITE) && memAck;
  assign stb.minorEnd = (state == ST_FINISH);
  assign stb.majorEnd = (state == ST_FINISH) && lastIter;
  assign stb.wrSel    = (state == ST_WRITE);

  assign memReq = (state == ST_READ) || (state == ST_WRITE);
  assign memWe  = (state == ST_WRITE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      beginCount <= '0; curCount <= '0;
      minorCh <= '0; majorCh <= '0;
      minorLinkEn <= 1'b0; majorLinkEn <= 1'b0;
      halfEn <= 1'b0; majorEn <= 1'b0; stopPeriph <= 1'b0;
      periphOn <= 1'b1; startPend <= 1'b0;
      activeFlag <= 1'b0; doneFlag <= 1'b0;
      irqHalf <= 1'b0; irqMajor <= 1'b0; linkReq <= 1'b0; linkCh <= '0;
    end else begin
      irqHalf  <= 1'b0;
      irqMajor <= 1'b0;
      linkReq  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (stb.loadCfg) begin
            beginCount  <= cfgIter[CNT_W-1:0];
            curCount    <= cfgIter[CNT_W-1:0];
            minorLinkEn <= cfgIter[CNT_W];
            minorCh     <= cfgMinorLinkCh;
            majorLinkEn <= cfgMajorLinkEn;
            majorCh     <= cfgMajorLinkCh;
            halfEn      <= cfgHalfIrqEn;
            majorEn     <= cfgMajorIrqEn;
            stopPeriph  <= cfgStopPeriphAtDone;
            startPend   <= cfgStart;
            periphOn    <= 1'b1;
            doneFlag    <= 1'b0;
          end else if (go) begin
            state      <= ST_READ;
            activeFlag <= 1'b1;
            doneFlag   <= 1'b0;
            startPend  <= 1'b0;
          end
        end
        ST_READ:
          if (memAck && rdUnitLast) state <= ST_WRITE;
        ST_WRITE:
          if (memAck && wrUnitLast) state <= minorLast ? ST_FINISH : ST_READ;
        ST_FINISH: begin
          state      <= ST_IDLE;
          activeFlag <= 1'b0;
          if (lastIter) begin
            curCount <= beginCount;
            doneFlag <= 1'b1;
            irqMajor <= majorEn;
            if (stopPeriph) periphOn <= 1'b0;
            if (majorLinkEn) begin
              linkReq <= 1'b1;
              linkCh  <= majorCh;
            end
          end else begin
            curCount <= countDec;
            irqHalf  <= halfEn && (countDec == (beginCount >> 1));
            if (minorLinkEn) begin
              linkReq <= 1'b1;
              linkCh  <= minorCh;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_loop_engine.sv
module dma_loop_engine
  import dma_loop_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int NB_W   = 32,
  parameter int DATA_W = 32,
  parameter int MOD_W  = 5,
  parameter int CNT_W  = 15,
  parameter int CH_W   = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgLoad,
  input  logic [ADDR_W-1:0] cfgSrcAddr,
  input  logic [ADDR_W-1:0] cfgDstAddr,
  input  logic [OFF_W-1:0]  cfgSrcOff,
  input  logic [OFF_W-1:0]  cfgDstOff,
  input  logic [2:0]        cfgSrcSize,
  input  logic [2:0]        cfgDstSize,
  input  logic [MOD_W-1:0]  cfgSrcMod,
  input  logic [MOD_W-1:0]  cfgDstMod,
  input  logic [NB_W-1:0]   cfgNBytes,
  input  logic [ADDR_W-1:0] cfgSrcLastAdj,
  input  logic [ADDR_W-1:0] cfgDstLastAdj,
  input  logic [CNT_W:0]    cfgIter,
  input  logic [CH_W-1:0]   cfgMinorLinkCh,
  input  logic              cfgMajorLinkEn,
  input  logic [CH_W-1:0]   cfgMajorLinkCh,
  input  logic              cfgHalfIrqEn,
  input  logic              cfgMajorIrqEn,
  input  logic              cfgStopPeriphAtDone,
  input  logic              cfgStart,
  input  logic              swStart,
  input  logic              periphReq,
  input  logic              linkIn,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [1:0]        memSize,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata,
  output logic [CNT_W-1:0]  curCount,
  output logic              activeFlag,
  output logic              doneFlag,
  output logic              cfgErr,
  output logic              irqHalf,
  output logic              irqMajor,
  output logic              linkReq,
  output logic [CH_W-1:0]   linkCh
);
  dpStrobe_t stb;
  logic cfgBad, rdUnitLast, wrUnitLast, minorLast;

  dma_loop_ctrl #(.CNT_W(CNT_W), .CH_W(CH_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgIter(cfgIter),
    .cfgMinorLinkCh(cfgMinorLinkCh), .cfgMajorLinkEn(cfgMajorLinkEn),
    .cfgMajorLinkCh(cfgMajorLinkCh), .cfgHalfIrqEn(cfgHalfIrqEn),
    .cfgMajorIrqEn(cfgMajorIrqEn), .cfgStopPeriphAtDone(cfgStopPeriphAtDone),
    .cfgStart(cfgStart), .swStart(swStart), .periphReq(periphReq),
    .linkIn(linkIn), .memAck(memAck), .cfgBad(cfgBad),
    .rdUnitLast(rdUnitLast), .wrUnitLast(wrUnitLast), .minorLast(minorLast),
    .stb(stb), .memReq(memReq), .memWe(memWe), .curCount(curCount),
    .activeFlag(activeFlag), .doneFlag(doneFlag), .cfgErr(cfgErr),
    .irqHalf(irqHalf), .irqMajor(irqMajor), .linkReq(linkReq), .linkCh(linkCh)
  );

  dma_loop_datapath #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .NB_W(NB_W),
                      .DATA_W(DATA_W), .MOD_W(MOD_W)) uPath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .cfgSrcAddr(cfgSrcAddr), .cfgDstAddr(cfgDstAddr),
    .cfgSrcOff(cfgSrcOff), .cfgDstOff(cfgDstOff),
    .cfgSrcSize(cfgSrcSize), .cfgDstSize(cfgDstSize),
    .cfgSrcMod(cfgSrcMod), .cfgDstMod(cfgDstMod), .cfgNBytes(cfgNBytes),
    .cfgSrcLastAdj(cfgSrcLastAdj), .cfgDstLastAdj(cfgDstLastAdj),
    .memRdata(memRdata), .memAddr(memAddr), .memSize(memSize),
    .memWdata(memWdata), .cfgBad(cfgBad), .rdUnitLast(rdUnitLast),
    .wrUnitLast(wrUnitLast), .minorLast(minorLast)
  );
endmodule

// File: rtl/dma_loop_checker.sv
module dma_loop_checker #(
  parameter int CNT_W = 15
) (
  input logic             clk,
  input logic             rstN,
  input logic             memReq,
  input logic [1:0]       memSize,
  input logic [CNT_W-1:0] curCount,
  input logic             activeFlag,
  input logic             doneFlag,
  input logic             cfgErr,
  input logic             irqHalf,
  input logic             irqMajor,
  input logic             linkReq
);
  a_r5_req_only_active: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> activeFlag);

  a_r2_size_code_legal: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memSize <= 2'd2));

  a_r6_done_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag |-> !activeFlag);

  a_r8_irq_with_done: assert property (@(posedge clk) disable iff (!rstN)
    irqMajor |-> (doneFlag && !activeFlag));

  a_r12_err_blocks_start: assert property (@(posedge clk) disable iff (!rstN)
    (cfgErr && !activeFlag) |=> !activeFlag);

  a_r9_link_after_loop: assert property (@(posedge clk) disable iff (!rstN)
    (linkReq || irqHalf) |-> !activeFlag);

  a_r5_count_steady: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && $past(memReq)) |-> $stable(curCount));
endmodule

bind dma_loop_engine dma_loop_checker #(.CNT_W(CNT_W)) uCheck (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memSize(memSize),
  .curCount(curCount), .activeFlag(activeFlag), .doneFlag(doneFlag),
  .cfgErr(cfgErr), .irqHalf(irqHalf), .irqMajor(irqMajor), .linkReq(linkReq)
);

// File: tb/dma_loop_engine_test.sv
module dma_loop_engine_test;
  typedef struct {
    logic [31:0] addr;
    int          nb;
    logic [31:0] data;
  } wrItem_t;

  logic clk = 0, rstN = 0;
  logic cfgLoad = 0;
  logic [31:0] cfgSrcAddr = 0, cfgDstAddr = 0, cfgNBytes = 0;
  logic [31:0] cfgSrcLastAdj = 0, cfgDstLastAdj = 0;
  logic [15:0] cfgSrcOff = 0, cfgDstOff = 0, cfgIter = 0;
  logic [2:0]  cfgSrcSize = 0, cfgDstSize = 0;
  logic [4:0]  cfgSrcMod = 0, cfgDstMod = 0;
  logic [5:0]  cfgMinorLinkCh = 0, cfgMajorLinkCh = 0;
  logic cfgMajorLinkEn = 0, cfgHalfIrqEn = 0, cfgMajorIrqEn = 0;
  logic cfgStopPeriphAtDone = 0, cfgStart = 0;
  logic swStart = 0, periphReq = 0, linkIn = 0;
  logic memReq, memWe, memAck = 0;
  logic [31:0] memAddr, memWdata, memRdata = 0;
  logic [1:0]  memSize;
  logic [14:0] curCount;
  logic activeFlag, doneFlag, cfgErr, irqHalf, irqMajor, linkReq;
  logic [5:0] linkCh;

  int total = 0, bad = 0;
  int halfCnt = 0, majCnt = 0, linkCnt = 0;
  logic [5:0] lastLinkCh = 0;
  logic [7:0] mem [0:255];
  wrItem_t expQ[$];
  logic [31:0] mSrc, mDst;
  bit finished = 0;

  dma_loop_engine uut (.*);

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] stepA(input logic [31:0] a, input logic [15:0] off, input logic [4:0] m);
    logic [31:0] sum, keep;
    sum  = a + {{16{off[15]}}, off};
    keep = (m == 0) ? 32'h0 : (32'hFFFF_FFFF << m);
    return (a & keep) | (sum & ~keep);
  endfunction

  // R2 R3 R4 R6: expected write stream of one minor loop
  task automatic modelIter(input bit lastOfMajor);
    int sb, db, ub;
    logic [7:0] tmp [0:3];
    sb = 1 << cfgSrcSize; db = 1 << cfgDstSize; ub = (sb > db) ? sb : db;
    for (int u = 0; u < int'(cfgNBytes) / ub; u++) begin
      int idx = 0;
      for (int r = 0; r < ub / sb; r++) begin
        for (int k = 0; k < sb; k++) begin
          tmp[idx] = mem[8'(mSrc + 32'(k))];
          idx++;
        end
        mSrc = stepA(mSrc, cfgSrcOff, cfgSrcMod);
      end
      for (int w = 0; w < ub / db; w++) begin
        wrItem_t it;
        it.addr = mDst; it.nb = db; it.data = 0;
        for (int k = 0; k < db; k++) it.data |= 32'(tmp[w*db + k]) << (8*k);
        expQ.push_back(it);
        mDst = stepA(mDst, cfgDstOff, cfgDstMod);
      end
    end
    if (lastOfMajor) begin
      mSrc += cfgSrcLastAdj;
      mDst += cfgDstLastAdj;
    end
  endtask

  // memory responder and write monitor (scoreboard pop side)
  always @(negedge clk) begin
    if (memAck) memAck = 0;
    else if (memReq) begin
      int nb;
      nb = 1 << memSize;
      memAck = 1;
      if (!memWe) begin
        memRdata = 0;
        for (int k = 0; k < nb; k++) memRdata |= 32'(mem[8'(memAddr + 32'(k))]) << (8*k);
      end else begin
        logic [31:0] mask;
        mask = (nb == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8*nb)) - 1);
        for (int k = 0; k < nb; k++) mem[8'(memAddr + 32'(k))] = memWdata[8*k +: 8];
        if (expQ.size() == 0) check(0, "R5 unexpected write", memAddr, 0);
        else begin
          wrItem_t e;
          e = expQ.pop_front();
          check(memAddr == e.addr, "R3/R4 write address", memAddr, e.addr);
          check(nb == e.nb, "R2 write size", nb, e.nb);
          check((memWdata & mask) == e.data, "R2 write data", memWdata & mask, e.data);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (irqHalf) halfCnt++;
    if (irqMajor) majCnt++;
    if (linkReq) begin linkCnt++; lastLinkCh = linkCh; end
  end

  task automatic loadDesc();
    @(negedge clk); cfgLoad = 1;
    @(negedge clk); cfgLoad = 0;
    mSrc = cfgSrcAddr; mDst = cfgDstAddr;
  endtask

  task automatic waitDone(input string req);
    int guard = 0;
    while (!activeFlag && guard < 20) begin @(negedge clk); guard++; end
    check(activeFlag, req, activeFlag, 1);
    while (activeFlag && guard < 2000) begin @(negedge clk); guard++; end
    @(negedge clk);
    check(expQ.size() == 0, "R5 all writes of minor loop seen", expQ.size(), 0);
  endtask

  // kind: 0 sw, 1 periph, 2 link
  task automatic runIter(input int kind, input bit lastOfMajor);
    modelIter(lastOfMajor);
    @(negedge clk);
    case (kind)
      1: periphReq = 1;
      2: linkIn = 1;
      default: swStart = 1;
    endcase
    @(negedge clk);
    swStart = 0; periphReq = 0; linkIn = 0;
    waitDone("R5 active after request");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!activeFlag && !doneFlag && !memReq, "R1 idle after reset", {activeFlag, doneFlag, memReq}, 0);
    check(curCount == 0, "R1 count zero", curCount, 0);
    check(cfgErr == 1, "R1 error with zero bytes", cfgErr, 1);
    rstN = 1;
    @(negedge clk);

    // T2: 4-byte reads, 1-byte writes, three iterations, source rewinds
    cfgSrcAddr = 32'h10; cfgSrcOff = 16'd4; cfgSrcSize = 2; cfgSrcMod = 0;
    cfgDstAddr = 32'h80; cfgDstOff = 16'd1; cfgDstSize = 0; cfgDstMod = 0;
    cfgNBytes = 8; cfgSrcLastAdj = -32'sd8; cfgDstLastAdj = 0;
    cfgIter = 16'd3; cfgHalfIrqEn = 1; cfgMajorIrqEn = 1;
    loadDesc();
    check(cfgErr == 0, "R12 valid descriptor accepted", cfgErr, 0);
    check(curCount == 3, "R6 count loaded", curCount, 3);
    runIter(0, 0);
    check(curCount == 2 && !doneFlag, "R5 count after first", curCount, 2);
    check(halfCnt == 0, "R7 no early half", halfCnt, 0);
    runIter(0, 0);
    check(curCount == 1, "R5 count after second", curCount, 1);
    check(halfCnt == 1, "R7 half point", halfCnt, 1);
    runIter(0, 1);
    check(curCount == 3, "R6 count reloaded", curCount, 3);
    check(doneFlag == 1, "R6 done set", doneFlag, 1);
    check(majCnt == 1, "R8 major interrupt", majCnt, 1);
    check(linkCnt == 0, "R9 no link when disabled", linkCnt, 0);

    // T3: byte reads with modulo wrap, 4-byte writes with negative offset
    cfgSrcAddr = 32'h24; cfgSrcOff = 16'd1; cfgSrcSize = 0; cfgSrcMod = 3;
    cfgDstAddr = 32'hBC; cfgDstOff = 16'hFFFC; cfgDstSize = 2; cfgDstMod = 0;
    cfgNBytes = 8; cfgSrcLastAdj = 0; cfgDstLastAdj = 32'h20;
    cfgIter = 16'd1; cfgHalfIrqEn = 1; cfgMajorIrqEn = 0;
    loadDesc();
    check(doneFlag == 0, "R6 done cleared by load", doneFlag, 0);
    runIter(0, 1);
    runIter(0, 1);
    check(halfCnt == 1, "R7 no half with count one", halfCnt, 1);
    check(majCnt == 1, "R8 major interrupt disabled", majCnt, 1);

    // T4: minor and major linking, peripheral stop
    cfgSrcAddr = 32'h40; cfgSrcOff = 16'd2; cfgSrcSize = 1; cfgSrcMod = 0;
    cfgDstAddr = 32'h60; cfgDstOff = 16'd2; cfgDstSize = 1; cfgDstMod = 0;
    cfgNBytes = 4; cfgSrcLastAdj = 0; cfgDstLastAdj = 0;
    cfgIter = 16'h8002; cfgMinorLinkCh = 6'd5; cfgMajorLinkEn = 1; cfgMajorLinkCh = 6'd9;
    cfgHalfIrqEn = 0; cfgStopPeriphAtDone = 1;
    loadDesc();
    runIter(1, 0);
    check(linkCnt == 1 && lastLinkCh == 5, "R9 minor link channel", lastLinkCh, 5);
    runIter(2, 1);
    check(linkCnt == 2 && lastLinkCh == 9, "R10 major link channel", lastLinkCh, 9);
    begin
      bit sawActive = 0;
      @(negedge clk); periphReq = 1;
      repeat (6) begin @(negedge clk); if (activeFlag) sawActive = 1; end
      periphReq = 0;
      @(negedge clk);
      check(!sawActive, "R11 periph ignored after done", sawActive, 0);
      check(curCount == 2 && doneFlag, "R11 state unchanged", curCount, 2);
    end
    runIter(0, 0);
    check(lastLinkCh == 5 && curCount == 1, "R11 software start still works", lastLinkCh, 5);

    // T5: rejected descriptors
    cfgMajorLinkEn = 0; cfgIter = 16'd1; cfgStopPeriphAtDone = 0;
    cfgSrcSize = 3;
    loadDesc();
    check(cfgErr == 1, "R12 bad size code", cfgErr, 1);
    begin
      bit sawActive = 0;
      @(negedge clk); swStart = 1; @(negedge clk); swStart = 0;
      repeat (3) begin @(negedge clk); if (activeFlag) sawActive = 1; end
      check(!sawActive, "R12 request ignored", sawActive, 0);
    end
    cfgSrcSize = 2; cfgNBytes = 6;
    loadDesc();
    check(cfgErr == 1, "R12 byte count not multiple", cfgErr, 1);
    cfgNBytes = 4; cfgIter = 16'd0;
    loadDesc();
    check(cfgErr == 1, "R12 zero count", cfgErr, 1);

    // T6: start bit
    cfgSrcAddr = 32'h50; cfgSrcOff = 16'd1; cfgSrcSize = 0;
    cfgDstAddr = 32'h70; cfgDstOff = 16'd1; cfgDstSize = 0;
    cfgNBytes = 2; cfgIter = 16'd1; cfgStart = 1;
    mSrc = cfgSrcAddr; mDst = cfgDstAddr;
    modelIter(1);
    loadDesc();
    cfgStart = 0;
    waitDone("R13 start bit runs iteration");
    check(doneFlag == 1, "R13 done after self start", doneFlag, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule